// File: doc/BRIEF.md
# Edge-Count Pulse Stream Transmitter

This block puts one already-encoded data word onto a single output wire as a packet of pulse groups. Every field value is sent as a number of rising edges, one more than the value, so that a zero still leaves a mark on the line. Each group is followed by a fixed low separator that the far end uses to split one value from the next. The receiver needs no clock recovery. It only counts edges and watches for the long low gaps.

A word is made of two count nibbles, up to eight two-bit bit positions (two slots for each of four segments, each slot with its own valid bit) and a flags nibble. A one-cycle `start` in the idle state captures all of these fields. The packet then goes out in this order: count nibble A, the valid slots of segments 0 and 1, count nibble B, the valid slots of segments 2 and 3, and finally the flags. All timing runs on a tick enable taken from the local clock divided by `DIV`, so no derived clock is ever made. The state machine has five states:

- `ST_IDLE`: the line is low and not busy. `start` moves it to `ST_SETUP` and captures the inputs.
- `ST_SETUP`: one tick with the line low. It then goes to `ST_HIGH` with the first group loaded.
- `ST_HIGH`: one tick with the line high. It then goes to `ST_LOW`.
- `ST_LOW`: one tick with the line low. If pulses remain it goes back to `ST_HIGH`. Otherwise it goes to `ST_GAP`.
- `ST_GAP`: `SEP_TICKS` ticks with the line low. It then goes to `ST_HIGH` if another group is present, or to `ST_IDLE` if none is left.

Top module: `edge_pulse_tx`

## Requirements
- R1: A value v is sent as v+1 pulses. Each pulse is high for exactly one tick and then low for one tick.
- R2: After the low tick of a group's last pulse, the line stays low for `SEP_TICKS` (default 4) further ticks. The next group's first pulse follows immediately after that, so groups are separated by exactly `SEP_TICKS`+1 low ticks.
- R3: Groups go out in this order: count nibble A (`cnt_in[3:0]`), slots 0 to 3, count nibble B (`cnt_in[7:4]`), slots 4 to 7, flags. Slot k is `idx_in[2k+1:2k]`. Slots 2s and 2s+1 belong to segment s, and slot 2s goes first.
- R4: A slot whose `idx_vld[k]` is 0 produces no group and adds no extra gap.
- R5: Both count nibbles and the flags nibble are always sent, even when zero, in which case the group is a single pulse.
- R6: `busy` rises on the clock after an accepted `start`. The line stays low for the one setup tick that follows. `busy` falls on the tick that ends the final separator.
- R7: A `start` seen while `busy` is high is ignored. The inputs are captured only when `start` is accepted, so changing them during a packet has no effect on it.
- R8: A tick occurs every `DIV` clocks, counted from reset. Apart from leaving idle, the output and state change only on ticks.
- R9: During and right after reset, `pulse_out` and `busy` are 0.
- R10: `pulse_out` is 0 whenever `busy` is 0. A `start` held high is accepted again on the first idle clock, which gives a one-clock idle gap between words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to send the presented word |
| cnt_in | input | 8 | Count nibbles, A in bits 3:0 and B in bits 7:4 |
| idx_in | input | 16 | Eight two-bit bit positions, slot k at bits 2k+1:2k |
| idx_vld | input | 8 | Valid bit for each slot |
| flags_in | input | 4 | Flags nibble, sent last |
| pulse_out | output | 1 | Registered single-wire pulse line |
| busy | output | 1 | High while a packet is in flight |

## Verification
The assertions assume that `start` and the data inputs change only between clock edges. They also assume that the tick enable is the only thing that advances a packet once it has left idle. The gap and pulse-width properties measure time in ticks, so they hold for any divide ratio. The stimulus drives every input on the falling edge and runs the design with a divide ratio of 2. This keeps the tick boundaries out of step with the start strobes and exercises the case where setup lasts more than one clock. It applies zero fields, maximum nibbles, sparse and full slot masks, a start held high across two words, and input changes with a stray start during a packet.

// File: rtl/etx_pkg.sv
package etx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_HIGH,
        ST_LOW,
        ST_GAP
    } etx_state_e;

endpackage

// File: rtl/etx_tick_gen.sv
module etx_tick_gen #(
    parameter int DIV = 1
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] div_q;

    assign tick = (div_q == CW'(DIV - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            div_q <= '0;
        else if (tick)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/etx_item_pick.sv
module etx_item_pick #(
    parameter int NITEM = 11,
    parameter int VW    = 4,
    parameter int PW    = 4
) (
    input  logic [NITEM*VW-1:0] item_flat,
    input  logic [NITEM-1:0]    item_on,
    input  logic [PW-1:0]       from_ptr,
    output logic                hit,
    output logic [PW-1:0]       hit_idx,
    output logic [VW-1:0]       hit_val
);
    // lowest present item at or after from_ptr
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        hit_val = '0;
        for (int i = NITEM - 1; i >= 0; i--) begin
            if (item_on[i] && (PW'(i) >= from_ptr)) begin
                hit     = 1'b1;
                hit_idx = PW'(i);
                hit_val = item_flat[i*VW +: VW];
            end
        end
    end
endmodule

// File: rtl/edge_pulse_tx.sv
module edge_pulse_tx #(
    parameter int NSEG      = 4,
    parameter int SLOTS     = 2,
    parameter int IDXW      = 2,
    parameter int NIBW      = 4,
    parameter int SEP_TICKS = 4,
    parameter int DIV       = 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [(NSEG/2)*NIBW-1:0]      cnt_in,
    input  logic [NSEG*SLOTS*IDXW-1:0]    idx_in,
    input  logic [NSEG*SLOTS-1:0]         idx_vld,
    input  logic [NIBW-1:0]               flags_in,
    output logic                          pulse_out,
    output logic                          busy
);
    import etx_pkg::*;

    localparam int NPAIR    = NSEG / 2;
    localparam int NSLOT    = NSEG * SLOTS;
    localparam int PER_PAIR = 1 + 2 * SLOTS;
    localparam int NITEM    = NPAIR * PER_PAIR + 1;
    localparam int PW       = $clog2(NITEM + 1);
    localparam int GW       = (SEP_TICKS > 1) ? $clog2(SEP_TICKS) : 1;

    etx_state_e state_q, state_d;
    logic [PW-1:0]   ptr_q, ptr_d;
    logic [NIBW-1:0] rem_q, rem_d;
    logic [GW-1:0]   gap_q, gap_d;

    logic [NPAIR*NIBW-1:0] cnt_q;
    logic [NSLOT*IDXW-1:0] idx_q;
    logic [NSLOT-1:0]      vld_q;
    logic [NIBW-1:0]       flg_q;

    logic                  tick;
    logic [NITEM*NIBW-1:0] item_flat;
    logic [NITEM-1:0]      item_on;
    logic                  hit;
    logic [PW-1:0]         hit_idx;
    logic [NIBW-1:0]       hit_val;
    logic                  accept;

    etx_tick_gen #(.DIV(DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    // packet item list: per pair a count nibble then its slots; flags last
    for (genvar p = 0; p < NPAIR; p++) begin : g_pair
        assign item_flat[(p*PER_PAIR)*NIBW +: NIBW] = cnt_q[p*NIBW +: NIBW];
        assign item_on[p*PER_PAIR]                  = 1'b1;
        for (genvar j = 0; j < 2*SLOTS; j++) begin : g_slot
            localparam int K = p*2*SLOTS + j;
            assign item_flat[(p*PER_PAIR+1+j)*NIBW +: NIBW] = NIBW'(idx_q[K*IDXW +: IDXW]);
            assign item_on[p*PER_PAIR+1+j]                  = vld_q[K];
        end
    end
    assign item_flat[(NITEM-1)*NIBW +: NIBW] = flg_q;
    assign item_on[NITEM-1]                  = 1'b1;

    etx_item_pick #(.NITEM(NITEM), .VW(NIBW), .PW(PW)) u_pick (
        .item_flat (item_flat),
        .item_on   (item_on),
        .from_ptr  (ptr_q),
        .hit       (hit),
        .hit_idx   (hit_idx),
        .hit_val   (hit_val)
    );

    assign accept = (state_q == ST_IDLE) && start;

    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        rem_d   = rem_q;
        gap_d   = gap_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_SETUP;
                    ptr_d   = '0;
                end
            end
            ST_SETUP: begin
                if (tick) begin
                    state_d = ST_HIGH;
                    ptr_d   = hit_idx + 1'b1;
                    rem_d   = hit_val;
                end
            end
            ST_HIGH: begin
                if (tick)
                    state_d = ST_LOW;
            end
            ST_LOW: begin
                if (tick) begin
                    if (rem_q == '0) begin
                        state_d = ST_GAP;
                        gap_d   = '0;
                    end else begin
                        state_d = ST_HIGH;
                        rem_d   = rem_q - 1'b1;
                    end
                end
            end
            ST_GAP: begin
                if (tick) begin
                    if (gap_q == GW'(SEP_TICKS - 1)) begin
                        if (hit) begin
                            state_d = ST_HIGH;
                            ptr_d   = hit_idx + 1'b1;
                            rem_d   = hit_val;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end else begin
                        gap_d = gap_q + 1'b1;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
            rem_q   <= '0;
            gap_q   <= '0;
            cnt_q   <= '0;
            idx_q   <= '0;
            vld_q   <= '0;
            flg_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            rem_q   <= rem_d;
            gap_q   <= gap_d;
            if (accept) begin
                cnt_q <= cnt_in;
                idx_q <= idx_in;
                vld_q <= idx_vld;
                flg_q <= flags_in;
            end
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_out <= 1'b0;
            busy      <= 1'b0;
        end else begin
            pulse_out <= (state_d == ST_HIGH);
            busy      <= (state_d != ST_IDLE);
        end
    end
endmodule

// File: rtl/edge_pulse_tx_chk.sv
module edge_pulse_tx_chk #(
    parameter int SEP = 4
) (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic tick,
    input logic pulse_out,
    input logic busy
);
    localparam int RW = $clog2(SEP + 3);

    logic [RW-1:0] low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            low_run <= '0;
        else if (!busy)
            low_run <= '0;
        else if (tick) begin
            if (pulse_out)
                low_run <= '0;
            else if (low_run != {RW{1'b1}})
                low_run <= low_run + 1'b1;
        end
    end

    a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !pulse_out);

    a_r1_one_tick_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_out && tick) |=> !pulse_out);

    a_r8_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> ($stable(pulse_out) && busy));

    a_r6_start_setup: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (busy && !pulse_out));

    a_r6_end_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (!pulse_out && !$past(pulse_out)));

    a_r2_gap_length: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_out) |-> ((low_run == RW'(1)) || (low_run == RW'(SEP + 1))));
endmodule

bind edge_pulse_tx edge_pulse_tx_chk #(.SEP(SEP_TICKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .tick      (tick),
    .pulse_out (pulse_out),
    .busy      (busy)
);

// File: tb/edge_pulse_tx_tb.sv
module edge_pulse_tx_tb;
    localparam int DIV_TB = 2;
    localparam int SEP    = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  cnt_in = '0;
    logic [15:0] idx_in = '0;
    logic [7:0]  idx_vld = '0;
    logic [3:0]  flags_in = '0;
    logic        pulse_out;
    logic        busy;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int edges  = 0;
    logic prev_p = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    edge_pulse_tx #(.DIV(DIV_TB), .SEP_TICKS(SEP)) u_dut (
        .clk (clk), .rst_n (rst_n), .start (start), .cnt_in (cnt_in),
        .idx_in (idx_in), .idx_vld (idx_vld), .flags_in (flags_in),
        .pulse_out (pulse_out), .busy (busy)
    );

    // behavioural reference: per-tick line levels in a queue
    bit q[$];
    bit m_busy = 1'b0;
    int m_cnt = 0;
    bit exp_p = 1'b0;
    bit exp_b = 1'b0;

    task automatic push_group(input int v);
        for (int i = 0; i <= v; i++) begin q.push_back(1'b1); q.push_back(1'b0); end
        for (int i = 0; i < SEP; i++) q.push_back(1'b0);
    endtask

    always @(posedge clk) begin
        bit tk;
        tk = (m_cnt == DIV_TB - 1);
        m_cnt = tk ? 0 : m_cnt + 1;
        if (!rst_n) begin
            q.delete(); m_busy = 1'b0; m_cnt = 0;
        end else if (!m_busy) begin
            if (start) begin
                q.push_back(1'b0);
                for (int p = 0; p < 2; p++) begin
                    push_group(int'(cnt_in[p*4 +: 4]));
                    for (int j = 0; j < 4; j++)
                        if (idx_vld[p*4+j]) push_group(int'(idx_in[(p*4+j)*2 +: 2]));
                end
                push_group(int'(flags_in));
                m_busy = 1'b1;
            end
        end else if (tk) begin
            void'(q.pop_front());
            if (q.size() == 0) m_busy = 1'b0;
        end
        exp_b = m_busy;
        exp_p = m_busy ? q[0] : 1'b0;
    end

    // per-clock comparison and edge counting, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (pulse_out !== exp_p || busy !== exp_b) begin
                fails++;
                $display("FAIL R1 R2 R3 R4 R8 line/busy at cycle %0d: actual %b/%b expected %b/%b",
                         cycles, pulse_out, busy, exp_p, exp_b);
            end
            if (pulse_out && !prev_p) edges++;
            prev_p = pulse_out;
        end
    end

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    function automatic int exp_edges(input logic [7:0] c, input logic [15:0] ix,
                                     input logic [7:0] v, input logic [3:0] f);
        int n;
        n = int'(c[3:0]) + int'(c[7:4]) + int'(f) + 3;
        for (int k = 0; k < 8; k++) if (v[k]) n += int'(ix[k*2 +: 2]) + 1;
        return n;
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_idle;
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    // send one word; poke=1 asserts a stray start and scrambles inputs mid-packet
    task automatic send(input logic [7:0] c, input logic [15:0] ix, input logic [7:0] v,
                        input logic [3:0] f, input bit poke, input string tag);
        int e;
        e = exp_edges(c, ix, v, f);
        @(negedge clk);
        cnt_in = c; idx_in = ix; idx_vld = v; flags_in = f; start = 1'b1;
        edges = 0;
        @(negedge clk);
        start = 1'b0;
        check({tag, " R6 busy after start"}, int'(busy), 1);
        check({tag, " R6 low during setup"}, int'(pulse_out), 0);
        if (poke) begin
            repeat (7) @(negedge clk);
            start = 1'b1; cnt_in = 8'hFF; idx_in = 16'hFFFF; idx_vld = 8'hFF; flags_in = 4'hF;
            @(negedge clk);
            start = 1'b0;
        end
        wait_idle();
        check({tag, " R1 R5 rising edge total"}, edges, e);
        check({tag, " R10 line low when idle"}, int'(pulse_out), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 line in reset", int'(pulse_out), 0);
        check("R9 busy in reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 line after reset", int'(pulse_out), 0);
        check("R9 busy after reset", int'(busy), 0);

        // R5: all-zero word, three single-pulse groups
        send(8'h00, 16'h0000, 8'h00, 4'h0, 1'b0, "R5 zero word");
        // R3: full slot mask, varied positions
        send(8'h22, 16'hE41B, 8'hFF, 4'h5, 1'b0, "R3 full mask");
        // R4: sparse mask
        send(8'h21, 16'h9C63, 8'b1001_0010, 4'h2, 1'b0, "R4 sparse mask");
        // maximum nibbles
        send(8'hFF, 16'hFFFF, 8'h01, 4'hF, 1'b0, "R1 max nibbles");
        // R7: stray start and input change while busy
        send(8'h10, 16'h0032, 8'b0000_0110, 4'h1, 1'b1, "R7 ignored start");

        // R10: start held across two words, each accepted after one idle clock
        @(negedge clk);
        cnt_in = 8'h01; idx_in = 16'h0007; idx_vld = 8'h03; flags_in = 4'h3;
        start = 1'b1; edges = 0;
        @(negedge clk);
        wait_idle();
        check("R10 idle clock between held starts", int'(busy), 0);
        @(negedge clk);
        check("R10 held start accepted again", int'(busy), 1);
        start = 1'b0;
        wait_idle();
        check("R10 R1 edges over two words", edges,
              2 * exp_edges(8'h01, 16'h0007, 8'h03, 4'h3));

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule